// File: doc/BRIEF.md
# DDR Burst-of-Two Common-I/O SRAM Core

This block models the control path of a pipelined double-data-rate SRAM that moves every access as a pair of words over one shared data bus. Commands are taken on the rising edge of the K clock. Write data follows one K cycle later, with one word on the K edge and one on the K# edge. Read data is returned in the same form on the output edges of the following cycle. The bus is released when no read burst is in flight.

A single fast clock at twice the K rate drives the design. The input `kphase_i` tells each edge apart: high marks a K edge and low marks a K# edge. A write burst is collected whole in a pending buffer and then written to a small register-file array on the next K edge. A read that reaches an address still held in that buffer takes the pending bytes lane by lane. Lanes that the pending write masked off are read from the array.

Top module: `ddr_cio_sram`

## Requirements
- R1: A command is taken only at a K edge (`kphase_i`=1) with `ld_ni`=0. `rw_i`=1 selects a read and `rw_i`=0 selects a write. `ld_ni`=1 is a no-operation, and a no-operation writes nothing whatever `rw_i` is. `kphase_i` alternates on every `clk_i` edge.
- R2: Each command moves two words. The first goes to `addr_i` and the second to `addr_i` with bit 0 inverted, so a start at bit0=1 wraps back to bit0=0.
- R3: For a write taken at K edge t, the first word and its mask are captured from `d_i`/`bw_ni` at K edge t+2, and the second at the K# edge t+3 (counted in `clk_i` edges).
- R4: For a read taken at K edge t, `q_o` carries the first word after edge t+2 and the second word after edge t+3. `q_oe_o` is high over both. With back-to-back reads, `q_oe_o` stays high on every half-cycle.
- R5: `bw_ni` is active low. Bit i enables lane `d_i[9i+8:9i]`. A mask is sampled with each beat, so the two beats of a burst may differ. A beat with all bits high writes nothing.
- R6: When a no-operation follows a read, the read burst still completes. `q_oe_o` falls at the K edge one K cycle after the no-operation. `q_o` is zero whenever `q_oe_o` is low.
- R7: A read returns the latest data for each byte lane. This includes a write burst that has been accepted but not yet written to the array.
- R8: `d_i`/`bw_ni` values on edges where no write beat is due are ignored.
- R9: Reset (`rst_ni` low, asynchronous) clears `q_o`, `q_oe_o` and every array word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, two edges per K cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kphase_i | input | 1 | 1 = this edge is K, 0 = this edge is K# |
| ld_ni | input | 1 | Command load, active low |
| rw_i | input | 1 | 1 read, 0 write |
| addr_i | input | ADDR_W | Burst start word address |
| bw_ni | input | LANES | Per-lane write enables, active low |
| d_i | input | LANES*LANE_W | Write data beat |
| q_o | output | LANES*LANE_W | Read data beat |
| q_oe_o | output | 1 | Bus drive enable |

## Verification
A buffered write burst is committed to the array on the same K edge that a read to the same address samples its first word, so the commit and the read fetch fall in one cycle. The bench provokes this by issuing a read at the K edge right after a write to the same pair of words. In one case all lanes are enabled, and in another only some lanes are enabled per beat. The first beat must then merge the pending lanes with the lanes still in the array, and the second beat must come from the array just updated. Both beats are compared with a reference word array that applies each beat with its own mask.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } cmd_e;
endpackage

// File: rtl/ddr_cmd_dec.sv
module ddr_cmd_dec
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kphase_i,
  input  logic              ld_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_arm_o,
  output logic              rd_arm_o,
  output logic [ADDR_W-1:0] cmd_base_o
);
  cmd_e cmd;

  always_comb begin
    if (ld_ni)     cmd = CMD_NOP;
    else if (rw_i) cmd = CMD_RD;
    else           cmd = CMD_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_arm_o   <= 1'b0;
      rd_arm_o   <= 1'b0;
      cmd_base_o <= '0;
    end else if (kphase_i) begin
      wr_arm_o <= (cmd == CMD_WR);
      rd_arm_o <= (cmd == CMD_RD);
      if (cmd != CMD_NOP) cmd_base_o <= addr_i;
    end
  end

  a_r1_k_then_kn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kphase_i |=> !kphase_i);
  a_r1_kn_then_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kphase_i |=> kphase_i);
  a_r1_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_arm_o && rd_arm_o));
endmodule

// File: rtl/ddr_wr_pend.sv
module ddr_wr_pend #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kphase_i,
  input  logic              wr_arm_i,
  input  logic [ADDR_W-1:0] cmd_base_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [LANES-1:0]  bw_ni,
  output logic              pend_valid_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] pend_base_o,
  output logic [DATA_W-1:0] pend_d0_o,
  output logic [DATA_W-1:0] pend_d1_o,
  output logic [LANES-1:0]  pend_be0_o,
  output logic [LANES-1:0]  pend_be1_o
);
  logic b1_due_q;

  assign commit_o = pend_valid_o && kphase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_o <= 1'b0;
      b1_due_q     <= 1'b0;
      pend_base_o  <= '0;
      pend_d0_o    <= '0;
      pend_d1_o    <= '0;
      pend_be0_o   <= '0;
      pend_be1_o   <= '0;
    end else if (kphase_i) begin
      if (pend_valid_o) pend_valid_o <= 1'b0;
      b1_due_q <= wr_arm_i;
      if (wr_arm_i) begin
        pend_base_o <= cmd_base_i;
        pend_d0_o   <= d_i;
        pend_be0_o  <= ~bw_ni;
      end
    end else if (b1_due_q) begin
      pend_d1_o    <= d_i;
      pend_be1_o   <= ~bw_ni;
      pend_valid_o <= 1'b1;
      b1_due_q     <= 1'b0;
    end
  end

  a_r7_commit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_o && kphase_i) |=> !pend_valid_o);
  a_r3_full_on_kn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_valid_o) |-> !$past(kphase_i));
endmodule

// File: rtl/ddr_sram_array.sv
module ddr_sram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr0_i,
  input  logic [ADDR_W-1:0] waddr1_i,
  input  logic [DATA_W-1:0] wdata0_i,
  input  logic [DATA_W-1:0] wdata1_i,
  input  logic [LANES-1:0]  wbe0_i,
  input  logic [LANES-1:0]  wbe1_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
        if (wbe0_i[l]) mem_q[waddr0_i] <= wdata0_i[l*LANE_W +: LANE_W];
        if (wbe1_i[l]) mem_q[waddr1_i] <= wdata1_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/ddr_rd_out.sv
module ddr_rd_out #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kphase_i,
  input  logic              rd_arm_i,
  input  logic [ADDR_W-1:0] cmd_base_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  input  logic              pend_valid_i,
  input  logic [ADDR_W-1:0] pend_base_i,
  input  logic [DATA_W-1:0] pend_d0_i,
  input  logic [DATA_W-1:0] pend_d1_i,
  input  logic [LANES-1:0]  pend_be0_i,
  input  logic [LANES-1:0]  pend_be1_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] q_o,
  output logic              q_oe_o
);
  logic [ADDR_W-1:0] out_base_q;
  logic              b1_due_q;
  logic [ADDR_W-1:0] pend_a1;
  logic              hit0, hit1;
  logic [DATA_W-1:0] merged;

  assign rd_addr_o = kphase_i ? cmd_base_i : {out_base_q[ADDR_W-1:1], ~out_base_q[0]};
  assign pend_a1   = {pend_base_i[ADDR_W-1:1], ~pend_base_i[0]};
  assign hit0      = pend_valid_i && (pend_base_i == rd_addr_o);
  assign hit1      = pend_valid_i && (pend_a1 == rd_addr_o);

  // lane-wise bypass of a burst not yet committed
  always_comb begin
    merged = arr_rdata_i;
    for (int l = 0; l < LANES; l++) begin
      if (hit0 && pend_be0_i[l]) merged[l*LANE_W +: LANE_W] = pend_d0_i[l*LANE_W +: LANE_W];
      if (hit1 && pend_be1_i[l]) merged[l*LANE_W +: LANE_W] = pend_d1_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o        <= '0;
      q_oe_o     <= 1'b0;
      b1_due_q   <= 1'b0;
      out_base_q <= '0;
    end else if (kphase_i) begin
      b1_due_q <= rd_arm_i;
      q_oe_o   <= rd_arm_i;
      q_o      <= rd_arm_i ? merged : '0;
      if (rd_arm_i) out_base_q <= cmd_base_i;
    end else if (b1_due_q) begin
      q_o      <= merged;
      b1_due_q <= 1'b0;
    end
  end

  a_r4_oe_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kphase_i && rd_arm_i) |=> q_oe_o);
  a_r6_oe_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kphase_i && !rd_arm_i) |=> !q_oe_o);
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_oe_o |-> (q_o == '0));
  a_r4_oe_on_k_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_oe_o) |-> $past(kphase_i));
endmodule

// File: rtl/ddr_cio_sram.sv
module ddr_cio_sram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kphase_i,
  input  logic              ld_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              q_oe_o
);
  logic              wr_arm, rd_arm;
  logic [ADDR_W-1:0] cmd_base;
  logic              pend_valid, commit;
  logic [ADDR_W-1:0] pend_base, rd_addr;
  logic [DATA_W-1:0] pend_d0, pend_d1, arr_rdata;
  logic [LANES-1:0]  pend_be0, pend_be1;

  ddr_cmd_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .kphase_i, .ld_ni, .rw_i, .addr_i,
    .wr_arm_o(wr_arm), .rd_arm_o(rd_arm), .cmd_base_o(cmd_base)
  );

  ddr_wr_pend #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pend (
    .clk_i, .rst_ni, .kphase_i,
    .wr_arm_i(wr_arm), .cmd_base_i(cmd_base), .d_i, .bw_ni,
    .pend_valid_o(pend_valid), .commit_o(commit), .pend_base_o(pend_base),
    .pend_d0_o(pend_d0), .pend_d1_o(pend_d1),
    .pend_be0_o(pend_be0), .pend_be1_o(pend_be1)
  );

  ddr_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i, .rst_ni, .we_i(commit),
    .waddr0_i(pend_base), .waddr1_i({pend_base[ADDR_W-1:1], ~pend_base[0]}),
    .wdata0_i(pend_d0), .wdata1_i(pend_d1),
    .wbe0_i(pend_be0), .wbe1_i(pend_be1),
    .raddr_i(rd_addr), .rdata_o(arr_rdata)
  );

  ddr_rd_out #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk_i, .rst_ni, .kphase_i,
    .rd_arm_i(rd_arm), .cmd_base_i(cmd_base), .arr_rdata_i(arr_rdata),
    .pend_valid_i(pend_valid), .pend_base_i(pend_base),
    .pend_d0_i(pend_d0), .pend_d1_i(pend_d1),
    .pend_be0_i(pend_be0), .pend_be1_i(pend_be1),
    .rd_addr_o(rd_addr), .q_o, .q_oe_o
  );
endmodule

// File: tb/ddr_cio_sram_tb.sv
module ddr_cio_sram_tb_top;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic          ld_n;
    logic          rw;
    logic [AW-1:0] a;
    logic [DW-1:0] d0;
    logic [LN-1:0] b0;
    logic [DW-1:0] d1;
    logic [LN-1:0] b1;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 4'd2,  18'h11111, 2'b00, 18'h22222, 2'b00},
    '{1'b0, 1'b0, 4'd5,  18'h0A0A0, 2'b00, 18'h0B0B0, 2'b00},
    '{1'b0, 1'b1, 4'd2,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b0, 1'b1, 4'd5,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b0, 1'b1, 4'd3,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b1, 1'b1, 4'd0,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b0, 1'b0, 4'd8,  18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01},
    '{1'b0, 1'b1, 4'd8,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b1, 1'b0, 4'd0,  18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00},
    '{1'b0, 1'b0, 4'd2,  18'h15555, 2'b11, 18'h0AAAA, 2'b01},
    '{1'b0, 1'b1, 4'd3,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b0, 1'b0, 4'd3,  18'h12345, 2'b00, 18'h2FEDC, 2'b10},
    '{1'b0, 1'b1, 4'd2,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b1, 1'b0, 4'd0,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b0, 1'b1, 4'd0,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b0, 1'b1, 4'd14, 18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b1, 1'b1, 4'd0,  18'h0,     2'b00, 18'h0,     2'b00},
    '{1'b1, 1'b1, 4'd0,  18'h0,     2'b00, 18'h0,     2'b00}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni, kphase_i, ld_ni, rw_i;
  logic [AW-1:0] addr_i;
  logic [LN-1:0] bw_ni;
  logic [DW-1:0] d_i, q_o;
  logic          q_oe_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [DEPTH];

  always #10 clk_i = ~clk_i;

  ddr_cio_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk_i, .rst_ni, .kphase_i, .ld_ni, .rw_i, .addr_i,
    .bw_ni, .d_i, .q_o, .q_oe_o
  );

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic mdl_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [LN-1:0] bn);
    for (int l = 0; l < LN; l++)
      if (!bn[l]) mdl[a][l*LW +: LW] = d[l*LW +: LW];
  endtask

  initial begin
    repeat (6000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic          pw, pr;
    logic [AW-1:0] prb;
    vec_t          pv;
    logic [DW-1:0] exp;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    rst_ni = 1'b0; kphase_i = 1'b0; ld_ni = 1'b1; rw_i = 1'b1;
    addr_i = '0; bw_ni = '0; d_i = '0;
    pw = 1'b0; pr = 1'b0; prb = '0; pv = '0;
    repeat (4) @(negedge clk_i);
    // R9 reset state
    check(q_oe_o == 1'b0, "R9 oe", {17'd0, q_oe_o}, '0);
    check(q_o == '0, "R9 q", q_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int j = 0; j < NV; j++) begin
      kphase_i = 1'b1;
      ld_ni = VEC[j].ld_n; rw_i = VEC[j].rw; addr_i = VEC[j].a;
      // junk with all lanes enabled when no beat is due (R8)
      d_i   = pw ? pv.d0 : (18'h2AA55 ^ DW'(j));
      bw_ni = pw ? pv.b0 : 2'b00;
      @(negedge clk_i);
      exp = pr ? mdl[prb] : '0;
      check(q_oe_o == pr, "R4 R6 oe beat0", {17'd0, q_oe_o}, {17'd0, pr});
      check(q_o == exp, "R2 R3 R5 R7 R8 R1 beat0", q_o, exp);
      kphase_i = 1'b0; ld_ni = 1'b1;
      d_i   = pw ? pv.d1 : (18'h15AA5 ^ DW'(j));
      bw_ni = pw ? pv.b1 : 2'b00;
      @(negedge clk_i);
      exp = pr ? mdl[{prb[AW-1:1], ~prb[0]}] : '0;
      check(q_oe_o == pr, "R4 R6 oe beat1", {17'd0, q_oe_o}, {17'd0, pr});
      check(q_o == exp, "R2 R3 R5 R7 R8 beat1", q_o, exp);
      if (pw) begin
        mdl_write(pv.a, pv.d0, pv.b0);
        mdl_write({pv.a[AW-1:1], ~pv.a[0]}, pv.d1, pv.b1);
      end
      pw  = !VEC[j].ld_n && !VEC[j].rw;
      pr  = !VEC[j].ld_n &&  VEC[j].rw;
      prb = VEC[j].a;
      pv  = VEC[j];
    end

    // R9 asynchronous reset while a read burst is on the bus
    kphase_i = 1'b1; ld_ni = 1'b0; rw_i = 1'b1; addr_i = 4'd2;
    @(negedge clk_i);
    kphase_i = 1'b0; ld_ni = 1'b1;
    @(negedge clk_i);
    kphase_i = 1'b1;
    @(negedge clk_i);
    check(q_oe_o == 1'b1, "R4 oe before reset", {17'd0, q_oe_o}, 18'd1);
    check(q_o == mdl[2], "R7 data before reset", q_o, mdl[2]);
    rst_ni = 1'b0;
    #1;
    check(q_oe_o == 1'b0, "R9 async oe", {17'd0, q_oe_o}, '0);
    check(q_o == '0, "R9 async q", q_o, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule